// File: doc/BRIEF.md
# Bit-Bang Pin Pattern Expander

This block turns a stream of configuration bytes into a stream of pin-state bytes for an 8-bit parallel bit-bang port. Every output byte sets the level of all port pins at once. Three pins matter: a serial data line, a configuration clock and an active-low configuration-start control. The control pin is held high for the whole stream. Each input bit becomes three consecutive pin states: data with the clock low, data with the clock high, then data with the clock low again. A downstream port that applies one byte per step therefore clocks the bit into the target device on the rising clock edge.

Both sides use valid/ready byte handshakes, and the output side honours full backpressure. A new input byte is taken only when every pin state of the previous byte has been consumed. The bits of each byte are sent least significant first.

Top module: `bitbang_expander`

## Requirements
- R1: In every output byte, bit 0 carries the current data bit, bit 1 carries the configuration clock and bit 2 carries the configuration-start control.
- R2: While out_valid is high, out_data bit 2 is 1 and bits 7 down to 3 are 0.
- R3: Each data bit d is emitted as the three bytes 0x04|d, 0x06|d, 0x04|d, in that order.
- R4: The bits of an input byte are emitted least significant bit first. For example, 0x02 gives the bit sequence 0,1,0,0,0,0,0,0.
- R5: One accepted input byte yields exactly 24 output handshakes. In the cycle after the 24th handshake, out_valid is 0 and in_ready is 1.
- R6: in_ready is 0 while any pin state of the current byte is still pending. A byte presented on in_data during that time is ignored and does not change the output stream.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value into the next cycle.
- R8: While rst_n is low, out_valid is 0 and in_ready is 1. A byte that was partly expanded when reset was applied is dropped, and the next accepted byte starts at its bit 0, phase one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Expander can take a byte |
| in_data | input | 8 | Configuration byte |
| out_valid | output | 1 | Pin-state byte available |
| out_ready | input | 1 | Port consumes the pin-state byte |
| out_data | output | 8 | Pin levels for the bit-bang port |

## Verification
The checker watches properties that hold on every cycle. The fixed control and zero pins hold on every valid byte, and the clock falls with the data held after a high-clock handshake. No byte is accepted while expansion is pending, output stays stable under backpressure, and a counter confirms 24 handshakes between accepted bytes. The bench alone shows the ordering properties. It sweeps all 256 byte values under an irregular ready pattern, which is what shows least-significant-first order and the exact triplet values. It also covers a decoy byte presented while busy and a reset in mid-byte followed by a clean restart.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  // Pin positions on the bit-bang port; a downstream port decodes these.
  localparam int unsigned PIN_DATA = 0;
  localparam int unsigned PIN_CLK  = 1;
  localparam int unsigned PIN_CTRL = 2;
  localparam int unsigned PHASES   = 3;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_RISE  = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;
endpackage

// File: rtl/bbx_sequencer.sv
module bbx_sequencer
  import bbx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_fire,
  input  logic   out_ready,
  output logic   busy,
  output phase_e phase,
  output logic   adv_bit
);
  logic             busy_q, busy_d;
  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             out_fire, last_bit, en;

  assign out_fire = busy_q & out_ready;
  assign last_bit = (idx_q == IDX_W'(BYTE_W - 1));
  assign adv_bit  = out_fire & (ph_q == PH_HOLD);
  assign en       = in_fire | out_fire;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    if (in_fire) begin
      busy_d = 1'b1;
      ph_d   = PH_SETUP;
      idx_d  = '0;
    end else if (out_fire) begin
      if (ph_q == PH_HOLD) begin
        ph_d = PH_SETUP;
        if (last_bit) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        ph_d = phase_e'(ph_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_SETUP;
      idx_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
    end
  end

  assign busy  = busy_q;
  assign phase = ph_q;
endmodule

// File: rtl/bbx_shifter.sv
module bbx_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              shift,
  output logic              cur_bit
);
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              en;

  assign en = load | shift;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_data;
    else if (shift) sh_d = sh_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh_q <= '0;
    else if (en) sh_q <= sh_d;
  end

  // Least significant bit goes out first.
  assign cur_bit = sh_q[0];
endmodule

// File: rtl/bbx_encoder.sv
module bbx_encoder
  import bbx_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  phase_e            phase,
  input  logic              data_bit,
  output logic [PORT_W-1:0] pins
);
  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      if (i == PIN_CTRL)      pins[i] = 1'b1;
      else if (i == PIN_CLK)  pins[i] = (phase == PH_RISE);
      else if (i == PIN_DATA) pins[i] = data_bit;
      else                    pins[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bitbang_expander.sv
module bitbang_expander
  import bbx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_data
);
  logic   busy, in_fire, adv_bit, cur_bit;
  phase_e phase;

  assign in_ready  = ~busy;
  assign in_fire   = in_valid & ~busy;
  assign out_valid = busy;

  bbx_sequencer #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .out_ready(out_ready),
    .busy(busy), .phase(phase), .adv_bit(adv_bit)
  );

  bbx_shifter #(.BYTE_W(BYTE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(in_fire), .load_data(in_data),
    .shift(adv_bit), .cur_bit(cur_bit)
  );

  bbx_encoder #(.PORT_W(PORT_W)) u_enc (
    .phase(phase), .data_bit(cur_bit), .pins(out_data)
  );
endmodule

// File: rtl/bbx_checker.sv
module bbx_checker
  import bbx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PORT_W = 8,
  localparam int unsigned PER_BYTE = BYTE_W * PHASES,
  localparam int unsigned CNT_W = $clog2(PER_BYTE + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_data
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else if (out_valid && out_ready) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  a_r2_fixed_pins: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[PIN_CTRL] && ((out_data >> 3) == '0)));

  // R3
  a_r3_clock_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data[PIN_CLK]) |=>
      (out_valid && !out_data[PIN_CLK] && (out_data[PIN_DATA] == $past(out_data[PIN_DATA]))));

  // R6
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  a_r5_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen_q) |-> (cnt_q == CNT_W'(PER_BYTE)));

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q < CNT_W'(PER_BYTE)));

  // R8
  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));
endmodule

bind bitbang_expander bbx_checker #(.BYTE_W(BYTE_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/sim_bitbang_expander.sv
`timescale 1ns/1ps
module sim_bitbang_expander;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  bitbang_expander u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_pin(input logic [7:0] b, input int k);
    logic d;
    d = b[k / 3];
    return 8'h04 | ((k % 3 == 1) ? 8'h02 : 8'h00) | {7'd0, d};
  endfunction

  function automatic logic next_ready(input bit full);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return full ? 1'b1 : (lfsr[0] | lfsr[1]);
  endfunction

  // Offer byte b, then drain and compare all 24 pin states.
  task automatic run_byte(input logic [7:0] b, input bit full, input bit decoy);
    int k;
    logic [7:0] prev;
    bit held;
    @(negedge clk);
    check(in_ready == 1'b1, "R5 ready before byte", in_ready, 1);
    in_valid = 1'b1;
    in_data  = b;
    out_ready = 1'b0;
    k = 0;
    held = 0;
    prev = '0;
    while (k < 24) begin
      @(negedge clk);
      in_valid = decoy;
      in_data  = ~b;
      check(out_valid == 1'b1, "R5 valid during byte", out_valid, 1);
      check(in_ready == 1'b0, "R6 busy blocks input", in_ready, 0);
      if (held) check(out_data == prev, "R7 stable under backpressure", out_data, prev);
      check(out_data == expect_pin(b, k), "R1 R3 R4 pin pattern", out_data, expect_pin(b, k));
      check(out_data[2] && out_data[7:3] == 5'd0, "R2 fixed pins", out_data, expect_pin(b, k));
      out_ready = next_ready(full);
      held = !out_ready;
      prev = out_data;
      if (out_ready) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R5 idle after 24",
          {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;

    // Directed: 0x02 gives bits 0,1,0,0,0,0,0,0
    run_byte(8'h02, 1'b1, 1'b0);

    // Full sweep with irregular backpressure; decoy input on odd values
    for (int v = 0; v < 256; v++) run_byte(v[7:0], 1'b0, v[0]);

    // Reset in mid-byte, then clean restart
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    out_ready = 1'b0;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 reset mid-byte", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    run_byte(8'hA5, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule